// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block produces the timed waveforms of an open-drain single-wire bus: bus reset sequences and single-bit time slots (write 0, write 1, read). The controlling logic picks the slot kind and a speed flag (standard or overdrive) and pulses `start`. The block pulls the line low through `bus_pull` and watches the line on `bus_in`. When the slot is over it raises `done` for one cycle and leaves the sampled value on `result`. All time is counted in ticks of a one-microsecond strobe, `us_tick`, so the same block runs at any system clock.

A reset holds the line low and then releases it. It then watches for a presence pulse from an attached device. A line that stays low after the reset pulse can mean an alarm or a short. In that case the block waits a bounded extra time for the line to rise. If the line rises, presence watching goes on from that rise. If the wait runs out, the line is reported as held low. Standard and overdrive speed each have their own complete set of durations.

States, in order of use: `ST_IDLE` waits for `start`. `start` with the reset kind goes to `ST_RLOW`, and any other kind goes to `ST_BIT`. `ST_BIT` goes to `ST_DONE` when the slot length is reached. `ST_RLOW` goes to `ST_RSTUCK` at the end of the reset pulse. `ST_RSTUCK` goes to `ST_RPRES` as soon as the line reads high, or to `ST_DONE` when the stuck-line limit runs out. `ST_RPRES` goes to `ST_DONE` when the recovery time has elapsed. `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `sw_slot_gen`

## Requirements
- R1: After reset, `bus_pull`, `busy` and `done` are 0 and `result` is 1.
- R2: Standard-speed bit slot (`slot_kind` 2 = write 1, 3 = read): the line is pulled for exactly 1 tick. The line is sampled on the 8th tick. `done` follows the 60th tick of the slot.
- R3: A write-0 slot (`slot_kind` 1) pulls the line for the whole slot (60 ticks standard, 6 overdrive) and returns `result` 0.
- R4: Overdrive bit slot (`od_mode` 1): pulled for 1 tick (write 1 / read), sampled on the 2nd tick, slot length 6 ticks.
- R5: Reset (`slot_kind` 0) pulls the line for exactly 480 ticks (48 overdrive). With the line free afterwards, `done` comes no sooner than 960 ticks (96 overdrive) after the first pulled tick.
- R6: After the line rises following a reset, a low seen 15 to 59 ticks after the rise (2 to 5 in overdrive) gives `result` 0 (presence). Without such a low, `result` is 1.
- R7: If the line is still low after the reset pulse, the block waits up to 3840 more ticks (384 overdrive). On expiry it ends with `result` 0.
- R8: If the line rises during that extra wait, presence watching starts from the rise. `done` then comes a further 480 ticks (48 overdrive) after the rise.
- R9: Changing `od_mode` without `start` causes no line activity and no `done`.
- R10: `start` while a slot is in progress is ignored. The running slot keeps its kind, speed and length.
- R11: `done` is a single-cycle pulse. `result` stays unchanged from one `done` until the next slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| start | input | 1 | Begin a slot (taken only when idle) |
| slot_kind | input | 2 | 0 reset, 1 write 0, 2 write 1, 3 read |
| od_mode | input | 1 | 1 selects overdrive timing for the slot |
| bus_in | input | 1 | Current level of the bus line |
| bus_pull | output | 1 | Open-drain enable, 1 pulls the line low |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| result | output | 1 | Sampled bit, or 0 for presence / held-low line |

## Verification
The bench goes after these corner cases:
- A presence pulse that starts well after the window closes. A detector with an open upper bound would report presence for it.
- A line held low past the reset pulse, both forever and for a finite time. A design that never bounds the wait would hang. One that starts recovery timing from the end of the reset pulse instead of from the rise would finish early.
- A late `start` arriving mid-slot. If it were taken, the slot length would be cut or stretched, and a reset would begin.
- The two speeds, mixed at random. A crossed timing set shows up as a wrong pulse length or sample point.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

    typedef enum logic [1:0] {
        SK_RESET = 2'd0,
        SK_WR0   = 2'd1,
        SK_WR1   = 2'd2,
        SK_READ  = 2'd3
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BIT    = 3'd1,
        ST_RLOW   = 3'd2,
        ST_RSTUCK = 3'd3,
        ST_RPRES  = 3'd4,
        ST_DONE   = 3'd5
    } slot_state_e;

endpackage

// File: rtl/sw_tim_sel.sv
module sw_tim_sel #(
    parameter int TW          = 13,
    parameter int N_BIT_LEN   = 60,
    parameter int N_BIT_LOW   = 1,
    parameter int N_SAMP      = 8,
    parameter int N_RST_LOW   = 480,
    parameter int N_RST_RECOV = 480,
    parameter int N_STUCK     = 3840,
    parameter int N_PD_LO     = 15,
    parameter int N_PD_HI     = 60,
    parameter int O_BIT_LEN   = 6,
    parameter int O_BIT_LOW   = 1,
    parameter int O_SAMP      = 2,
    parameter int O_RST_LOW   = 48,
    parameter int O_RST_RECOV = 48,
    parameter int O_STUCK     = 384,
    parameter int O_PD_LO     = 2,
    parameter int O_PD_HI     = 6
) (
    input  logic          od,
    output logic [TW-1:0] bit_len,
    output logic [TW-1:0] bit_low,
    output logic [TW-1:0] bit_samp,
    output logic [TW-1:0] rst_low,
    output logic [TW-1:0] rst_recov,
    output logic [TW-1:0] stuck_max,
    output logic [TW-1:0] pd_lo,
    output logic [TW-1:0] pd_hi
);
    localparam int NF = 8;

    // Field order: slot length, short pull, sample, reset pull,
    // recovery, stuck limit, window open, window close.
    localparam int STD_SET [NF] = '{N_BIT_LEN, N_BIT_LOW, N_SAMP, N_RST_LOW,
                                    N_RST_RECOV, N_STUCK, N_PD_LO, N_PD_HI};
    localparam int OVD_SET [NF] = '{O_BIT_LEN, O_BIT_LOW, O_SAMP, O_RST_LOW,
                                    O_RST_RECOV, O_STUCK, O_PD_LO, O_PD_HI};

    logic [TW-1:0] fld [NF];

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign fld[i] = od ? TW'(OVD_SET[i]) : TW'(STD_SET[i]);
    end

    assign bit_len   = fld[0];
    assign bit_low   = fld[1];
    assign bit_samp  = fld[2];
    assign rst_low   = fld[3];
    assign rst_recov = fld[4];
    assign stuck_max = fld[5];
    assign pd_lo     = fld[6];
    assign pd_hi     = fld[7];

endmodule

// File: rtl/sw_phase_cnt.sv
module sw_phase_cnt #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/sw_pres_det.sv
module sw_pres_det #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] win_lo,
    input  logic [TW-1:0] win_hi,
    input  logic          line,
    output logic          seen
);
    logic in_win;

    assign in_win = (cnt >= win_lo) && (cnt < win_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else if (!en) begin
            seen <= 1'b0;
        end else if (in_win && !line) begin
            seen <= 1'b1;
        end
    end
endmodule

// File: rtl/sw_slot_gen.sv
module sw_slot_gen
    import sw_slot_pkg::*;
#(
    parameter int N_BIT_LEN   = 60,
    parameter int N_BIT_LOW   = 1,
    parameter int N_SAMP      = 8,
    parameter int N_RST_LOW   = 480,
    parameter int N_RST_RECOV = 480,
    parameter int N_STUCK     = 3840,
    parameter int N_PD_LO     = 15,
    parameter int N_PD_HI     = 60,
    parameter int O_BIT_LEN   = 6,
    parameter int O_BIT_LOW   = 1,
    parameter int O_SAMP      = 2,
    parameter int O_RST_LOW   = 48,
    parameter int O_RST_RECOV = 48,
    parameter int O_STUCK     = 384,
    parameter int O_PD_LO     = 2,
    parameter int O_PD_HI     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       start,
    input  logic [1:0] slot_kind,
    input  logic       od_mode,
    input  logic       bus_in,
    output logic       bus_pull,
    output logic       busy,
    output logic       done,
    output logic       result
);
    // Largest count ever reached, with margin for the compare on cnt+1.
    localparam int MAXCNT = N_STUCK + N_RST_RECOV + N_RST_LOW + 2;
    localparam int TW     = $clog2(MAXCNT);

    slot_state_e   state, nxt;
    slot_kind_e    cur_kind;
    logic          cur_od;
    logic          samp_q;

    logic [TW-1:0] cnt, cnt_inc;
    logic          cnt_clr;
    logic          fin, res_nxt, samp_hit, pres_seen;
    logic [TW-1:0] bit_len, bit_low, bit_samp, rst_low, rst_recov;
    logic [TW-1:0] stuck_max, pd_lo, pd_hi, low_len;

    sw_tim_sel #(
        .TW(TW),
        .N_BIT_LEN(N_BIT_LEN), .N_BIT_LOW(N_BIT_LOW), .N_SAMP(N_SAMP),
        .N_RST_LOW(N_RST_LOW), .N_RST_RECOV(N_RST_RECOV), .N_STUCK(N_STUCK),
        .N_PD_LO(N_PD_LO), .N_PD_HI(N_PD_HI),
        .O_BIT_LEN(O_BIT_LEN), .O_BIT_LOW(O_BIT_LOW), .O_SAMP(O_SAMP),
        .O_RST_LOW(O_RST_LOW), .O_RST_RECOV(O_RST_RECOV), .O_STUCK(O_STUCK),
        .O_PD_LO(O_PD_LO), .O_PD_HI(O_PD_HI)
    ) u_tim (
        .od(cur_od),
        .bit_len(bit_len), .bit_low(bit_low), .bit_samp(bit_samp),
        .rst_low(rst_low), .rst_recov(rst_recov), .stuck_max(stuck_max),
        .pd_lo(pd_lo), .pd_hi(pd_hi)
    );

    sw_phase_cnt #(.TW(TW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(us_tick), .cnt(cnt)
    );

    sw_pres_det #(.TW(TW)) u_pres (
        .clk(clk), .rst_n(rst_n), .en(state == ST_RPRES), .cnt(cnt),
        .win_lo(pd_lo), .win_hi(pd_hi), .line(bus_in), .seen(pres_seen)
    );

    assign cnt_inc  = cnt + TW'(1);
    assign low_len  = (cur_kind == SK_WR0) ? bit_len : bit_low;
    assign samp_hit = (state == ST_BIT) && us_tick && (cnt_inc == bit_samp);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Slot context: kind and speed captured at start, sample, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_kind <= SK_RESET;
            cur_od   <= 1'b0;
            samp_q   <= 1'b1;
            result   <= 1'b1;
        end else begin
            if (state == ST_IDLE && start) begin
                cur_kind <= slot_kind_e'(slot_kind);
                cur_od   <= od_mode;
            end
            if (samp_hit) begin
                samp_q <= bus_in;
            end
            if (fin) begin
                result <= res_nxt;
            end
        end
    end

    // Next state
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        fin     = 1'b0;
        res_nxt = 1'b1;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (start) begin
                    nxt = (slot_kind_e'(slot_kind) == SK_RESET) ? ST_RLOW : ST_BIT;
                end
            end
            ST_BIT: begin
                if (us_tick && cnt_inc == bit_len) begin
                    nxt     = ST_DONE;
                    fin     = 1'b1;
                    res_nxt = samp_q;
                end
            end
            ST_RLOW: begin
                if (us_tick && cnt_inc == rst_low) begin
                    nxt     = ST_RSTUCK;
                    cnt_clr = 1'b1;
                end
            end
            ST_RSTUCK: begin
                if (bus_in) begin
                    nxt     = ST_RPRES;
                    cnt_clr = 1'b1;
                end else if (us_tick && cnt_inc == stuck_max) begin
                    nxt     = ST_DONE;
                    fin     = 1'b1;
                    res_nxt = 1'b0;
                end
            end
            ST_RPRES: begin
                if (us_tick && cnt_inc == rst_recov) begin
                    nxt     = ST_DONE;
                    fin     = 1'b1;
                    res_nxt = ~pres_seen;
                end
            end
            ST_DONE: begin
                nxt     = ST_IDLE;
                cnt_clr = 1'b1;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        bus_pull = 1'b0;
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        unique case (state)
            ST_BIT:  bus_pull = (cnt < low_len);
            ST_RLOW: bus_pull = 1'b1;
            default: bus_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/sw_slot_chk.sv
module sw_slot_chk
    import sw_slot_pkg::*;
#(
    parameter int N_BIT_LEN   = 60,
    parameter int N_RST_LOW   = 480,
    parameter int N_RST_RECOV = 480,
    parameter int O_BIT_LEN   = 6,
    parameter int O_RST_LOW   = 48,
    parameter int O_RST_RECOV = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       us_tick,
    input logic       busy,
    input logic       done,
    input logic       bus_pull,
    input logic       result,
    input slot_kind_e cur_kind,
    input logic       cur_od
);
    int ck_ticks;
    int ck_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_ticks <= 0;
            ck_low   <= 0;
        end else if (!busy) begin
            ck_ticks <= 0;
            ck_low   <= 0;
        end else begin
            if (!done && us_tick) ck_ticks <= ck_ticks + 1;
            if (bus_pull && us_tick) ck_low <= ck_low + 1;
        end
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_pull);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(result));

    p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cur_kind) && $stable(cur_od)));

    p_bit_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_kind != SK_RESET) |->
            (ck_ticks == (cur_od ? O_BIT_LEN : N_BIT_LEN)));

    p_wr0_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_kind == SK_WR0) |->
            (ck_low == (cur_od ? O_BIT_LEN : N_BIT_LEN)));

    p_rst_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_kind == SK_RESET) |->
            (ck_ticks >= (cur_od ? O_RST_LOW + O_RST_RECOV : N_RST_LOW + N_RST_RECOV)));

    p_rst_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_kind == SK_RESET) |->
            (ck_low == (cur_od ? O_RST_LOW : N_RST_LOW)));

endmodule

bind sw_slot_gen sw_slot_chk #(
    .N_BIT_LEN(N_BIT_LEN), .N_RST_LOW(N_RST_LOW), .N_RST_RECOV(N_RST_RECOV),
    .O_BIT_LEN(O_BIT_LEN), .O_RST_LOW(O_RST_LOW), .O_RST_RECOV(O_RST_RECOV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .busy(busy), .done(done),
    .bus_pull(bus_pull), .result(result), .cur_kind(cur_kind), .cur_od(cur_od)
);

// File: tb/sim_sw_slot_gen.sv
`timescale 1ns/1ps
module sim_sw_slot_gen;
    localparam int TICK_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic [1:0] slot_kind = 2'd0;
    logic       od_mode = 1'b0;
    logic       dev_pull = 1'b0;
    logic       bus_in, bus_pull, busy, done, result;

    int n_chk = 0;
    int n_bad = 0;
    int m_ticks = 0, m_low = 0, m_done = 0, m_quiet = 0;
    logic m_res = 1'b1;
    int tdiv = 0;

    always #5 clk = ~clk;

    assign bus_in = ~(bus_pull | dev_pull);

    sw_slot_gen u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
        .slot_kind(slot_kind), .od_mode(od_mode), .bus_in(bus_in),
        .bus_pull(bus_pull), .busy(busy), .done(done), .result(result)
    );

    always @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        us_tick <= (tdiv == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        if (busy && !done && us_tick) m_ticks++;
        if (bus_pull && us_tick) m_low++;
        if (done) begin m_done++; m_res = result; end
        if (bus_pull || done || busy) m_quiet++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(negedge clk); while (!us_tick);
        end
    endtask

    function automatic int slot_len(input bit od);
        return od ? 6 : 60;
    endfunction
    function automatic int rlow(input bit od);
        return od ? 48 : 480;
    endfunction
    function automatic int rrec(input bit od);
        return od ? 48 : 480;
    endfunction
    function automatic int stuck_lim(input bit od);
        return od ? 384 : 3840;
    endfunction

    // mode: 0 quiet line, 1 device drives a 0 in a bit slot,
    // 2 presence at p_at for p_hold, 3 line stuck forever,
    // 4 stuck for s_len then presence (p_at>0) or none
    task automatic run_op(input logic [1:0] k, input bit od, input int mode,
                          input int s_len, input int p_at, input int p_hold,
                          input bit exp_res);
        int lo_t, hi_t, exp_low;
        string rq;
        @(negedge clk);
        slot_kind = k; od_mode = od; start = 1'b1;
        m_ticks = 0; m_low = 0; m_done = 0;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) begin
            while (!bus_pull) @(negedge clk);
            dev_pull = 1'b1;
            wait_ticks(od ? 3 : 15);
            dev_pull = 1'b0;
        end else if (mode >= 2) begin
            while (!bus_pull) @(negedge clk);
            if (mode >= 3) dev_pull = 1'b1;
            while (bus_pull) @(negedge clk);
            if (mode == 3) begin
                while (m_done == 0) @(negedge clk);
                dev_pull = 1'b0;
            end else begin
                if (mode == 4) begin
                    wait_ticks(s_len);
                    dev_pull = 1'b0;
                end
                if (p_at > 0) begin
                    wait_ticks(p_at);
                    dev_pull = 1'b1;
                    wait_ticks(p_hold);
                    dev_pull = 1'b0;
                end
            end
        end
        while (m_done == 0) @(negedge clk);
        repeat (3) @(negedge clk);

        if (k == 2'd0) begin
            exp_low = rlow(od);
            if (mode == 3) begin
                lo_t = rlow(od) + stuck_lim(od); hi_t = lo_t + 1;
            end else if (mode == 4) begin
                lo_t = rlow(od) + s_len + rrec(od) - 1; hi_t = lo_t + 3;
            end else begin
                lo_t = rlow(od) + rrec(od); hi_t = lo_t + 1;
            end
            chk(m_ticks >= lo_t && m_ticks <= hi_t, "R5 reset length", m_ticks, lo_t);
            chk(m_low == exp_low, "R5 reset pull", m_low, exp_low);
            rq = (mode == 3) ? "R7 stuck result" : (mode == 4) ? "R8 recovered result" : "R6 presence result";
            chk(m_res == exp_res, rq, int'(m_res), int'(exp_res));
        end else begin
            exp_low = (k == 2'd1) ? slot_len(od) : 1;
            chk(m_ticks == slot_len(od), od ? "R4 slot length" : "R2 slot length", m_ticks, slot_len(od));
            chk(m_low == exp_low, (k == 2'd1) ? "R3 write0 pull" : (od ? "R4 short pull" : "R2 short pull"),
                m_low, exp_low);
            chk(m_res == exp_res, od ? "R4 sample" : "R2 sample", int'(m_res), int'(exp_res));
        end
        chk(m_done == 1, "R11 single done", m_done, 1);
        chk(!busy && !bus_pull, "R11 back idle", int'(busy), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        summary();
    end

    initial begin
        int unsigned seed;
        logic held;
        seed = $urandom(32'h5eed);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!bus_pull && !busy && !done, "R1 outputs quiet", int'({bus_pull, busy, done}), 0);
        chk(result == 1'b1, "R1 result", int'(result), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 speed flag toggles alone
        m_quiet = 0;
        for (int i = 0; i < 12; i++) begin
            od_mode = ~od_mode;
            repeat (4) @(negedge clk);
        end
        chk(m_quiet == 0, "R9 no activity on toggle", m_quiet, 0);

        // Directed bit slots, both speeds
        for (int s = 0; s < 2; s++) begin
            run_op(2'd1, s[0], 0, 0, 0, 0, 1'b0);
            run_op(2'd2, s[0], 0, 0, 0, 0, 1'b1);
            run_op(2'd3, s[0], 1, 0, 0, 0, 1'b0);
            run_op(2'd3, s[0], 0, 0, 0, 0, 1'b1);
        end

        // R10 start during a slot
        @(negedge clk);
        slot_kind = 2'd2; od_mode = 1'b0; start = 1'b1;
        m_ticks = 0; m_low = 0; m_done = 0;
        @(negedge clk); start = 1'b0;
        wait_ticks(20);
        slot_kind = 2'd0; od_mode = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (m_done == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(m_ticks == 60, "R10 length kept", m_ticks, 60);
        chk(m_low == 1, "R10 kind kept", m_low, 1);
        chk(!busy, "R10 no second slot", int'(busy), 0);

        // Reset corner cases
        run_op(2'd0, 1'b0, 2, 0, 25, 50, 1'b0);
        run_op(2'd0, 1'b0, 2, 0, 72, 20, 1'b1);
        run_op(2'd0, 1'b0, 0, 0, 0, 0, 1'b1);
        run_op(2'd0, 1'b1, 2, 0, 3, 1, 1'b0);
        run_op(2'd0, 1'b1, 2, 0, 9, 2, 1'b1);
        run_op(2'd0, 1'b0, 3, 0, 0, 0, 1'b0);
        run_op(2'd0, 1'b1, 3, 0, 0, 0, 1'b0);
        run_op(2'd0, 1'b0, 4, 200, 25, 50, 1'b0);
        run_op(2'd0, 1'b0, 4, 100, 0, 0, 1'b1);
        run_op(2'd0, 1'b1, 4, 30, 3, 1, 1'b0);

        // R11 result held while idle
        held = result;
        repeat (40) @(negedge clk);
        chk(result == held, "R11 result held", int'(result), int'(held));

        // Random mix
        for (int i = 0; i < 36; i++) begin
            logic [1:0] k;
            bit od;
            int r, at;
            k  = 2'($urandom % 4);
            od = 1'($urandom % 2);
            r  = int'($urandom % 3);
            case (k)
                2'd0: begin
                    if (r == 0) run_op(k, od, 0, 0, 0, 0, 1'b1);
                    else if (r == 1) begin
                        at = od ? 3 + int'($urandom % 2) : 18 + int'($urandom % 35);
                        run_op(k, od, 2, 0, at, od ? 1 : 2 * at, 1'b0);
                    end else begin
                        at = od ? 9 : 66 + int'($urandom % 20);
                        run_op(k, od, 2, 0, at, od ? 2 : 20, 1'b1);
                    end
                end
                2'd1: run_op(k, od, 0, 0, 0, 0, 1'b0);
                2'd2: run_op(k, od, 0, 0, 0, 0, 1'b1);
                default: begin
                    if (r == 0) run_op(k, od, 1, 0, 0, 0, 1'b0);
                    else run_op(k, od, 0, 0, 0, 0, 1'b1);
                end
            endcase
        end
        summary();
    end
endmodule